// File: doc/BRIEF.md
# Interrupt Echo Register Peripheral

This block is a small register-bus slave that helps measure how long a host takes to answer an interrupt. Software stamps the time, then writes any value to the trigger word. The block raises a level interrupt request and keeps the written value in a holding register. The interrupt service routine then reads the acknowledge word. That single read returns the held value, which proves the interrupt came from this block, and it also drops the request.

The request level is also driven unchanged onto a separate tap pin, so an instrument can time the whole span from trigger write to acknowledge read. The write and read sides have separate address inputs, so a trigger write and an acknowledge read can fall in the same clock cycle. A fixed rule decides that case. Read data is registered and comes back one clock after the strobe, marked by a one-cycle valid pulse. Writes take effect at the clock edge that samples them, with no wait states.

Top module: `irq_echo_regs`

## Requirements
- R1: A synchronous active-high reset clears the interrupt request, the holding register, `rd_valid` and `rd_data` to zero.
- R2: A write of any data value to byte address 0x00 (the trigger word) makes `irq_req` read 1 from the cycle after the write strobe.
- R3: A read of byte address 0x00 returns the holding register on `rd_data` in the cycle after the strobe, and leaves `irq_req` unchanged.
- R4: A read of byte address 0x04 (the acknowledge word) returns the holding register in the cycle after the strobe, and `irq_req` reads 0 from that same cycle.
- R5: Once set, `irq_req` stays at 1 in every cycle until an acknowledge read; while it is clear and no trigger write occurs, it stays at 0.
- R6: `irq_tap` equals `irq_req` in every cycle.
- R7: When a trigger write and an acknowledge read share a cycle, the write wins: `irq_req` stays 1, the holding register takes the new value, and the read returns the value held before that cycle.
- R8: A write to byte address 0x04, or to any address other than 0x00, changes neither `irq_req` nor the holding register.
- R9: `rd_valid` is 1 in exactly the cycles that follow a cycle with `rd_en` high. A read of any address other than 0x00 and 0x04, unaligned addresses included, returns zero.
- R10: A trigger write while `irq_req` is already 1 keeps it at 1 and replaces the held value with the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | DW | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| irq_req | output | 1 | Level interrupt request |
| irq_tap | output | 1 | Copy of the request for an external instrument |

## Verification
The bench builds the block with its default parameters: a 32-bit data width, a 4-bit byte address, and the trigger and acknowledge words at 0x00 and 0x04. With a 4-bit address, the unmapped word at 0x08 and the unaligned addresses are within reach. This lets the bench show that reads of those addresses return zero and that writes to them have no effect. The full 32-bit width lets the bench use data patterns that touch every bit of the holding register, including all-ones and zero.

// File: rtl/echo_pkg.sv
package echo_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_TRIG = 2'd1,
        TGT_ACK  = 2'd2
    } tgt_e;
endpackage

// File: rtl/echo_decode.sv
module echo_decode
    import echo_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int TRIG_OFS = 0,
    parameter int ACK_OFS  = 4
) (
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt
);
    localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_OFS);
    localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_OFS);

    // Exact byte-address match: unaligned addresses fall out as unmapped.
    always_comb begin
        tgt = TGT_NONE;
        if (strobe) begin
            if (addr == TRIG_A)
                tgt = TGT_TRIG;
            else if (addr == ACK_A)
                tgt = TGT_ACK;
        end
    end
endmodule

// File: rtl/echo_core.sv
module echo_core
    import echo_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  tgt_e          wr_tgt,
    input  logic [DW-1:0] wdata,
    input  tgt_e          rd_tgt,
    output logic          flag_q,
    output logic [DW-1:0] hold_q
);
    typedef struct packed {
        logic          flag;
        logic [DW-1:0] hold;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_tgt == TGT_ACK)
            st_d.flag = 1'b0;
        // The trigger write is applied last, so it wins over a same-cycle acknowledge.
        if (wr_tgt == TGT_TRIG) begin
            st_d.flag = 1'b1;
            st_d.hold = wdata;
        end
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flag_q = st_q.flag;
    assign hold_q = st_q.hold;
endmodule

// File: rtl/echo_rdpath.sv
module echo_rdpath
    import echo_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_stb,
    input  tgt_e          rd_tgt,
    input  logic [DW-1:0] hold,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_stb;
        if (rd_stb)
            rd_d.data = (rd_tgt != TGT_NONE) ? hold : '0;
        if (rst)
            rd_d = '0;
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
    end

    assign rdata  = rd_q.data;
    assign rvalid = rd_q.valid;
endmodule

// File: rtl/irq_echo_regs.sv
module irq_echo_regs
    import echo_pkg::*;
#(
    parameter int DW       = 32,
    parameter int ADDR_W   = 4,
    parameter int TRIG_OFS = 0,
    parameter int ACK_OFS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    output logic              irq_req,
    output logic              irq_tap
);
    tgt_e          wr_tgt;
    tgt_e          rd_tgt;
    logic          flag_q;
    logic [DW-1:0] hold_q;

    echo_decode #(.ADDR_W(ADDR_W), .TRIG_OFS(TRIG_OFS), .ACK_OFS(ACK_OFS)) u_wr_dec (
        .strobe (wr_en),
        .addr   (wr_addr),
        .tgt    (wr_tgt)
    );

    echo_decode #(.ADDR_W(ADDR_W), .TRIG_OFS(TRIG_OFS), .ACK_OFS(ACK_OFS)) u_rd_dec (
        .strobe (rd_en),
        .addr   (rd_addr),
        .tgt    (rd_tgt)
    );

    echo_core #(.DW(DW)) u_core (
        .clk    (clk),
        .rst    (rst),
        .wr_tgt (wr_tgt),
        .wdata  (wr_data),
        .rd_tgt (rd_tgt),
        .flag_q (flag_q),
        .hold_q (hold_q)
    );

    echo_rdpath #(.DW(DW)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_stb (rd_en),
        .rd_tgt (rd_tgt),
        .hold   (hold_q),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

    assign irq_req = flag_q;
    assign irq_tap = flag_q;
endmodule

// File: rtl/echo_regs_chk.sv
module echo_regs_chk #(
    parameter int DW       = 32,
    parameter int ADDR_W   = 4,
    parameter int TRIG_OFS = 0,
    parameter int ACK_OFS  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DW-1:0]     rd_data,
    input logic              rd_valid,
    input logic              irq_req,
    input logic              irq_tap,
    input logic [DW-1:0]     hold_q
);
    localparam logic [ADDR_W-1:0] TA = ADDR_W'(TRIG_OFS);
    localparam logic [ADDR_W-1:0] AA = ADDR_W'(ACK_OFS);

    logic trig, ack, rd_trig, rd_unmapped, wr_other;
    assign trig        = wr_en && (wr_addr == TA);
    assign ack         = rd_en && (rd_addr == AA);
    assign rd_trig     = rd_en && (rd_addr == TA);
    assign rd_unmapped = rd_en && (rd_addr != TA) && (rd_addr != AA);
    assign wr_other    = wr_en && (wr_addr != TA);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_req && !rd_valid && rd_data == '0 && hold_q == '0));
    a_r2_trig_sets: assert property (@(posedge clk) disable iff (rst)
        trig |=> irq_req);
    a_r3_read_trig_no_side_effect: assert property (@(posedge clk) disable iff (rst)
        (rd_trig && !trig) |=> (irq_req == $past(irq_req)));
    a_r3_read_returns_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_trig || ack) |=> (rd_data == $past(hold_q)));
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && !trig) |=> !irq_req);
    a_r5_level_held: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !ack) |=> irq_req);
    a_r5_clear_held: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && !trig) |=> !irq_req);
    a_r6_tap_follows: assert property (@(posedge clk) disable iff (rst)
        irq_tap == irq_req);
    a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
        (trig && ack) |=> (irq_req && hold_q == $past(wr_data)));
    a_r8_other_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_other && !ack) |=> (irq_req == $past(irq_req) && hold_q == $past(hold_q)));
    a_r9_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    a_r9_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        rd_unmapped |=> (rd_data == '0));
    a_r10_overwrite: assert property (@(posedge clk) disable iff (rst)
        trig |=> (hold_q == $past(wr_data)));
endmodule

bind irq_echo_regs echo_regs_chk #(
    .DW(DW), .ADDR_W(ADDR_W), .TRIG_OFS(TRIG_OFS), .ACK_OFS(ACK_OFS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .irq_req  (irq_req),
    .irq_tap  (irq_tap),
    .hold_q   (hold_q)
);

// File: tb/tb_irq_echo_regs.sv
`timescale 1ns/1ps
module tb_irq_echo_regs;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          irq_req;
    logic          irq_tap;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Behavioural reference state
    bit              m_flag = 1'b0;
    logic [DW-1:0]   m_hold = '0;
    bit              m_rv = 1'b0;
    logic [DW-1:0]   m_rdata = '0;

    always #10 clk = ~clk;

    irq_echo_regs dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .irq_req(irq_req), .irq_tap(irq_tap)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, advance the model, compare all outputs after the edge.
    task automatic step(input string tag,
                        input bit we, input int wa, input logic [DW-1:0] wd,
                        input bit re, input int ra);
        bit            trig, ack, n_flag;
        logic [DW-1:0] n_hold;
        @(negedge clk);
        wr_en = we; wr_addr = AW'(wa); wr_data = wd;
        rd_en = re; rd_addr = AW'(ra);
        trig   = we && (wa == 0);
        ack    = re && (ra == 4);
        n_flag = trig ? 1'b1 : (ack ? 1'b0 : m_flag);
        n_hold = trig ? wd : m_hold;
        if (rst) begin
            n_flag = 1'b0; n_hold = '0; m_rv = 1'b0; m_rdata = '0;
        end else begin
            m_rv = re;
            if (re) m_rdata = (ra == 0 || ra == 4) ? m_hold : '0;
        end
        m_flag = n_flag;
        m_hold = n_hold;
        @(posedge clk);
        #2;
        chk(tag, {31'd0, irq_req}, {31'd0, m_flag});
        chk("R6", {31'd0, irq_tap}, {31'd0, m_flag});
        chk("R9", {31'd0, rd_valid}, {31'd0, m_rv});
        if (m_rv) chk(tag, rd_data, m_rdata);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 0, '0, 1'b0, 0);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        idle("R1");
        idle("R1");
        chk("R1", rd_data, '0);
        rst = 1'b0;
        idle("R1");

        // R2: trigger write raises the request
        step("R2", 1'b1, 0, 32'hDEAD_BEEF, 1'b0, 0);
        // R5: level held over idle cycles
        for (int i = 0; i < 3; i++) idle("R5");
        // R3: read of trigger word returns value, request untouched
        step("R3", 1'b0, 0, '0, 1'b1, 0);
        chk("R3", rd_data, 32'hDEAD_BEEF);
        // R8: write to acknowledge word ignored
        step("R8", 1'b1, 4, 32'h0000_1234, 1'b0, 0);
        step("R8", 1'b1, 8, 32'h0000_5678, 1'b0, 0);
        step("R8", 1'b1, 1, 32'h0000_9ABC, 1'b0, 0);
        step("R8", 1'b0, 0, '0, 1'b1, 0);
        chk("R8", rd_data, 32'hDEAD_BEEF);
        // R10: repeated trigger overwrites hold, flag stays
        step("R10", 1'b1, 0, 32'h0000_0000, 1'b0, 0);
        step("R10", 1'b1, 0, 32'hA5A5_5A5A, 1'b0, 0);
        // R4: acknowledge read returns hold and clears
        step("R4", 1'b0, 0, '0, 1'b1, 4);
        chk("R4", rd_data, 32'hA5A5_5A5A);
        chk("R4", {31'd0, irq_req}, 32'd0);
        for (int i = 0; i < 2; i++) idle("R5");
        // R8: write to 0x04 while clear does not raise
        step("R8", 1'b1, 4, 32'hFFFF_FFFF, 1'b0, 0);
        // R9: unmapped and unaligned reads return zero
        step("R9", 1'b0, 0, '0, 1'b1, 8);
        chk("R9", rd_data, '0);
        step("R9", 1'b0, 0, '0, 1'b1, 2);
        chk("R9", rd_data, '0);
        // R7: same-cycle trigger and acknowledge
        step("R7", 1'b1, 0, 32'h0000_0011, 1'b0, 0);
        step("R7", 1'b1, 0, 32'h0000_0022, 1'b1, 4);
        chk("R7", rd_data, 32'h0000_0011);
        chk("R7", {31'd0, irq_req}, 32'd1);
        step("R7", 1'b0, 0, '0, 1'b1, 0);
        chk("R7", rd_data, 32'h0000_0022);
        // R9: back-to-back reads, first acknowledges
        step("R9", 1'b0, 0, '0, 1'b1, 4);
        step("R9", 1'b0, 0, '0, 1'b1, 4);
        step("R9", 1'b0, 0, '0, 1'b1, 0);
        idle("R9");
        // Pattern sweep over trigger/acknowledge cycles
        for (int i = 0; i < 16; i++) begin
            step("R2", 1'b1, 0, 32'h0101_0101 * i ^ 32'hF0F0_0F0F, 1'b0, 0);
            if (i % 3 == 0) step("R10", 1'b1, 0, ~(32'h1 << i), 1'b0, 0);
            if (i % 2 == 0) idle("R5");
            step("R4", (i % 4 == 1), 4, 32'hFFFF_FFFF, 1'b1, 4);
            idle("R5");
        end
        // R1: reset while request is set
        step("R1", 1'b1, 0, 32'hFFFF_FFFF, 1'b0, 0);
        rst = 1'b1;
        idle("R1");
        rst = 1'b0;
        chk("R1", {31'd0, irq_req}, 32'd0);
        step("R1", 1'b0, 0, '0, 1'b1, 0);
        chk("R1", rd_data, '0);
        idle("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule